// File: doc/BRIEF.md
# Timer Capture Unit with Edge Prescaler

This unit watches one asynchronous input pin and takes a snapshot of a free-running 16-bit timer whenever a selected pin event occurs. The snapshot is held in a capture register, and a sticky flag goes high so that software knows a new value is waiting. Software clears the flag with a one-cycle strobe.

A 4-bit mode input selects the event. Four codes are capture modes:
- every falling edge;
- every rising edge;
- every fourth rising edge;
- every sixteenth rising edge.

The all-zero code switches the unit off and returns it to its reset state. Any other code keeps the unit idle. The pin passes through a two-flop synchroniser before edge detection, so the unit reacts to an edge a fixed number of clocks after the pin moves.

The unit is placed next to a timer. It needs only the timer's count value; the timer itself and the register access path belong to the surrounding logic.

Top module: `edge_capture_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cap_value` becomes 0 and `cap_flag` becomes 0.
- R2: In mode 4'b0100, a falling edge of `pin_in` is captured. The pin is sampled at clock edge k1, and the value of `timer_val` present at clock edge k3 (two edges after k1) is loaded into `cap_value` at k3.
- R3: In mode 4'b0101, every rising edge of `pin_in` is captured, with the same k3 timing as R2. Falling edges are not captured.
- R4: In mode 4'b0110, only every fourth rising edge is captured, counted from the mode becoming active. Falling edges and the other rising edges leave `cap_value` and `cap_flag` unchanged.
- R5: In mode 4'b0111, only every sixteenth rising edge is captured, counted in the same way as R4.
- R6: Mode 4'b0000 clears `cap_value` to 0, clears `cap_flag` and clears the edge prescale count, one clock after the code is applied.
- R7: Whenever `mode` differs from its value on the previous clock, the prescale count is cleared. The first capture after the change therefore needs a full four or sixteen rising edges.
- R8: `cap_flag` rises one clock after the edge at which `cap_value` is loaded (at k4). It stays high until a clock edge that sees `flag_clr` high, and then goes low.
- R9: If `flag_clr` is high at the same clock edge at which a new capture would raise the flag, the flag is high after that edge.
- R10: Under any mode code other than 4'b0000, 4'b0100, 4'b0101, 4'b0110 and 4'b0111, pin edges change neither `cap_value` nor `cap_flag`. `flag_clr` still clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous event pin |
| timer_val | input | 16 | Current timer count to be captured |
| mode | input | 4 | Event select; 4'b0000 is off |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| cap_value | output | 16 | Last captured timer value |
| cap_flag | output | 1 | Sticky capture-pending flag |

## Verification
The hardest case to reach from the ports is a clear strobe that lands on exactly the clock at which a new capture raises the flag. The bench counts clocks from the pin transition and raises `flag_clr` only for the fourth edge after it. The flag is left set from an earlier capture, so that a design in which the clear wins would show a low flag.

A second hard case is a prescale count left part-way. The bench stops a divide-by-four count after two edges, then changes the mode away and back. It expects that edges counted before the change do not bring the next capture forward.

// File: rtl/ecu_pkg.sv
// Package: mode codes and widths shared by the capture unit.
// Assumes: mode is a 4-bit field decoded only by this unit.
package ecu_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] MODE_OFF   = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_FALL  = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_RISE  = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_DIVA  = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_DIVB  = 4'b0111;
endpackage

// File: rtl/ecu_edge_sync.sv
// Module: synchronises the asynchronous pin and produces one-cycle
// rise/fall pulses. Assumes the pin is stable for at least one clock
// between transitions. Edge history is not cleared by the off mode.
module ecu_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Purpose: shift the pin through the synchroniser chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], pin_in};
            end
        end
    endgenerate

    // Purpose: remember the previous synchronised level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
    assign fall_o = ~sync_q[STAGES-1] & prev_q;

    // A rise pulse must be followed by a settled high level.
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
    assert_fall_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);
endmodule

// File: rtl/ecu_prescale.sv
// Module: decodes the mode, counts rising edges for the divided modes and
// issues a one-cycle hit when an event qualifies. Assumes the divide
// values fit in CNT_W bits. The count clears on any mode change, and no
// hit is issued in the cycle of the change.
module ecu_prescale
    import ecu_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16,
    parameter int CNT_W = $clog2(DIV_B)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic              rise,
    input  logic              fall,
    output logic              hit
);
    localparam logic [CNT_W-1:0] TERM_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] TERM_B = CNT_W'(DIV_B - 1);

    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              changed;
    logic              div_mode;
    logic [CNT_W-1:0]  term;

    assign changed = (mode != mode_q);

    // Purpose: select the divide terminal for the current mode.
    always_comb begin
        div_mode = 1'b0;
        term     = TERM_A;
        if (mode == MODE_DIVA) begin
            div_mode = 1'b1;
            term     = TERM_A;
        end else if (mode == MODE_DIVB) begin
            div_mode = 1'b1;
            term     = TERM_B;
        end
    end

    // Purpose: decide whether this cycle's edge is a capture event.
    always_comb begin
        hit = 1'b0;
        if (!changed) begin
            unique case (mode)
                MODE_FALL: hit = fall;
                MODE_RISE: hit = rise;
                MODE_DIVA,
                MODE_DIVB: hit = rise && (cnt_q == term);
                default:   hit = 1'b0;
            endcase
        end
    end

    // Purpose: track the previous mode to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_OFF;
        else        mode_q <= mode;
    end

    // Purpose: count qualifying rising edges in the divided modes.
    always_ff @(posedge clk) begin
        if (!rst_n || changed || !div_mode)
            cnt_q <= '0;
        else if (rise)
            cnt_q <= (cnt_q == term) ? '0 : cnt_q + 1'b1;
    end

    assert_hit_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (rise || fall));
    assert_diva_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DIVA && !changed) |-> (cnt_q <= TERM_A));
    assert_mode_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != mode_q) |=> (cnt_q == '0));
    assert_off_no_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |-> !hit);
endmodule

// File: rtl/ecu_flag.sv
// Module: sticky capture flag. It is set one clock after a capture, and
// a set wins over a coincident clear. The off mode clears it.
module ecu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic off,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    logic hit_q;

    // Purpose: delay the capture event by one clock.
    always_ff @(posedge clk) begin
        if (!rst_n || off) hit_q <= 1'b0;
        else               hit_q <= hit;
    end

    // Purpose: hold the flag, giving priority to set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n || off) flag <= 1'b0;
        else if (hit_q)    flag <= 1'b1;
        else if (clr)      flag <= 1'b0;
    end

    assert_set_after_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !off) |=> ##1 (flag || off || $past(off)));
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr && !off) |=> flag);
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && clr && !off) |=> flag);
endmodule

// File: rtl/edge_capture_unit.sv
// Module: top of the timer capture unit. It loads timer_val into
// cap_value on a qualifying pin event and raises a sticky flag one clock
// later. Assumes timer_val is synchronous to clk.
module edge_capture_unit
    import ecu_pkg::*;
#(
    parameter int TW      = 16,
    parameter int STAGES  = 2,
    parameter int DIV_A   = 4,
    parameter int DIV_B   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_in,
    input  logic [TW-1:0]     timer_val,
    input  logic [MODE_W-1:0] mode,
    input  logic              flag_clr,
    output logic [TW-1:0]     cap_value,
    output logic              cap_flag
);
    logic rise_w;
    logic fall_w;
    logic hit_w;
    logic off_w;

    assign off_w = (mode == MODE_OFF);

    ecu_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .rise_o (rise_w),
        .fall_o (fall_w)
    );

    ecu_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .rise  (rise_w),
        .fall  (fall_w),
        .hit   (hit_w)
    );

    ecu_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .off   (off_w),
        .hit   (hit_w),
        .clr   (flag_clr),
        .flag  (cap_flag)
    );

    // Purpose: capture register, cleared by reset and by the off mode.
    always_ff @(posedge clk) begin
        if (!rst_n || off_w) cap_value <= '0;
        else if (hit_w)      cap_value <= timer_val;
    end

    assert_value_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_w && !off_w) |=> $stable(cap_value));
    assert_off_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        off_w |=> (cap_value == '0 && !cap_flag));
endmodule

// File: tb/sim_edge_capture_unit.sv
module sim_edge_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pin_in;
    logic [15:0] timer_val;
    logic [3:0]  mode;
    logic        flag_clr;
    logic [15:0] cap_value;
    logic        cap_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model
    logic [15:0] exp_val;
    logic        exp_flag;
    int          pcnt;

    always #2 clk = ~clk;

    edge_capture_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .timer_val(timer_val),
        .mode(mode), .flag_clr(flag_clr), .cap_value(cap_value), .cap_flag(cap_flag)
    );

    task automatic tick();
        @(negedge clk);
        timer_val = timer_val + 16'd1;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_mode(input logic [3:0] m);
        tick();
        mode = m;
        pcnt = 0;
        if (m == 4'b0000) begin
            exp_val  = '0;
            exp_flag = 1'b0;
        end
        tick();
        tick();
    endtask

    function automatic bit qualifies(input logic rising);
        int div;
        div = 0;
        if (mode == 4'b0100) return !rising;
        if (mode == 4'b0101) return rising;
        if (mode == 4'b0110) div = 4;
        else if (mode == 4'b0111) div = 16;
        if (div == 0 || !rising) return 0;
        pcnt++;
        if (pcnt == div) begin
            pcnt = 0;
            return 1;
        end
        return 0;
    endfunction

    // Drive one pin transition and check capture value (k3) and flag (k4).
    task automatic do_edge(input logic v, input bit do_clr, input string tag);
        logic [15:0] t0;
        bit q;
        bit f_before;
        tick();
        pin_in = v;
        t0 = timer_val;
        q = qualifies(v);
        f_before = exp_flag;
        tick();
        tick();
        tick();
        if (q) exp_val = 16'(t0 + 16'd2);
        chk(cap_value == exp_val, {tag, " value"}, cap_value, exp_val);
        chk(cap_flag == f_before, {tag, " flag latency R8"}, cap_flag, f_before);
        tick();
        if (q) exp_flag = 1'b1;
        chk(cap_flag == exp_flag, {tag, " flag"}, cap_flag, exp_flag);
        if (do_clr) begin
            flag_clr = 1'b1;
            tick();
            flag_clr = 1'b0;
            exp_flag = 1'b0;
            chk(cap_flag == 1'b0, {tag, " clear R8"}, cap_flag, 0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_in = 1'b0; timer_val = 16'h1200;
        mode = 4'b0000; flag_clr = 1'b0;
        exp_val = '0; exp_flag = 1'b0; pcnt = 0;
        tick(); tick(); tick();
        // R1: reset state
        chk(cap_value == 16'd0, "R1 value", cap_value, 0);
        chk(cap_flag == 1'b0, "R1 flag", cap_flag, 0);
        rst_n = 1'b1;
        tick();

        // Sweep of the four capture modes: R2 R3 R4 R5
        set_mode(4'b0100);
        for (int i = 0; i < 6; i++) begin
            do_edge(1'b1, 1, "R2 fall-mode rise");
            do_edge(1'b0, 1, "R2 fall-mode fall");
        end
        set_mode(4'b0101);
        for (int i = 0; i < 6; i++) begin
            do_edge(1'b1, 1, "R3 rise-mode rise");
            do_edge(1'b0, 1, "R3 rise-mode fall");
        end
        set_mode(4'b0110);
        for (int i = 0; i < 12; i++) begin
            do_edge(1'b1, 1, "R4 div4 rise");
            do_edge(1'b0, 1, "R4 div4 fall");
        end
        set_mode(4'b0111);
        for (int i = 0; i < 34; i++) begin
            do_edge(1'b1, 1, "R5 div16 rise");
            do_edge(1'b0, 1, "R5 div16 fall");
        end

        // R7: partial count discarded by a mode change
        set_mode(4'b0110);
        for (int i = 0; i < 2; i++) begin
            do_edge(1'b1, 1, "R7 partial");
            do_edge(1'b0, 1, "R7 partial");
        end
        set_mode(4'b0111);
        set_mode(4'b0110);
        for (int i = 0; i < 4; i++) begin
            do_edge(1'b1, 1, "R7 after change");
            do_edge(1'b0, 1, "R7 after change");
        end

        // R9: clear coinciding with the flag set
        set_mode(4'b0101);
        do_edge(1'b1, 0, "R9 prep");
        do_edge(1'b0, 0, "R9 prep");
        begin
            logic [15:0] t0;
            tick();
            pin_in = 1'b1;
            t0 = timer_val;
            tick(); tick(); tick();
            flag_clr = 1'b1;
            tick();
            flag_clr = 1'b0;
            chk(cap_flag == 1'b1, "R9 set wins", cap_flag, 1);
            chk(cap_value == 16'(t0 + 16'd2), "R9 value", cap_value, 16'(t0 + 16'd2));
            exp_val = 16'(t0 + 16'd2);
            exp_flag = 1'b1;
        end
        do_edge(1'b0, 0, "R9 tail");

        // R10: inactive codes ignore edges, flag still clearable
        set_mode(4'b1000);
        for (int i = 0; i < 3; i++) begin
            do_edge(1'b1, 0, "R10 code 1000");
            do_edge(1'b0, 0, "R10 code 1000");
        end
        set_mode(4'b0011);
        do_edge(1'b1, 0, "R10 code 0011");
        do_edge(1'b0, 1, "R10 code 0011 clr");

        // R6: off clears value and flag
        set_mode(4'b0101);
        do_edge(1'b1, 0, "R6 prep");
        tick();
        mode = 4'b0000;
        tick();
        chk(cap_value == 16'd0, "R6 value", cap_value, 0);
        chk(cap_flag == 1'b0, "R6 flag", cap_flag, 0);
        exp_val = '0; exp_flag = 1'b0; pcnt = 0;
        do_edge(1'b0, 0, "R6 off edge");
        do_edge(1'b1, 0, "R6 off edge");
        do_edge(1'b0, 0, "R6 off edge");
        set_mode(4'b0110);
        for (int i = 0; i < 4; i++) begin
            do_edge(1'b1, 1, "R6 after off");
            do_edge(1'b0, 1, "R6 after off");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule